// File: doc/BRIEF.md
# Configuration Request Packet Builder

This block converts one configuration-space access (bus, device, function, register offset, access width, direction and write data) into a four-dword configuration request packet. It sends that packet one dword per beat on a valid/ready stream. The first beat is marked as start of packet and the last as end of packet. The block is intended to sit in front of a root port's transmit path. A host-side sequencer presents an access, and the builder produces the three header dwords and the single data dword.

The builder chooses between a local (Type 0) and a forwarded (Type 1) request by comparing the target bus with the secondary bus number. It derives the byte enables from the access width and the low two offset bits. It places write data into the addressed byte lanes and forms the dword-aligned register address. The root and secondary bus numbers, together with all request fields, are captured when the request is accepted. A packet in flight is therefore unaffected by later input changes. Only one packet is in flight at a time.

Top module: `cfg_tlp_builder`

## Requirements
- R1: Dword 0 holds the format/type code in bits [31:24], zeros in [23:10] and a length of 1 in [9:0]. The codes are 0x04 for a local read, 0x44 for a local write, 0x05 for a forwarded read and 0x45 for a forwarded write.
- R2: A forwarded (Type 1) code is used only when the target bus is strictly greater than the secondary bus. Equal or smaller bus numbers produce a local (Type 0) code.
- R3: Dword 1 holds {root bus, 8'h00} in [31:16], the tag in [15:8], zeros in [7:4] and the byte enables in [3:0]. The tag is 0x1D for reads and 0x10 for writes.
- R4: Dword 2 holds the bus in [31:24], the device in [23:19] and the function in [18:16]. Bits [15:12] and [1:0] are zero, and offset bits [11:2] appear in [11:2].
- R5: Access width is encoded 0 = byte, 1 = halfword, 2 or 3 = dword. With lane = offset[1:0], the byte enables are 1<<lane for a byte access and (3<<lane) truncated to 4 bits for a halfword access. A dword access uses 4'hF.
- R6: For a write, the data dword is wdata[7:0]<<(8*lane) for a byte access and wdata[15:0]<<(8*lane) truncated to 32 bits for a halfword access. A dword access sends wdata unchanged. A read always sends a data dword of zero.
- R7: Beats leave in the order dword 0, 1, 2, 3. Start of packet is set only on dword 0 and end of packet only on dword 3.
- R8: req_ready is high when idle. After an accepted request, the first beat is valid in the next cycle, and req_ready stays low until the cycle after the end-of-packet beat is accepted.
- R9: While out_valid is high and out_ready is low, the beat's data and markers hold unchanged in the next cycle.
- R10: In the cycle after reset, out_valid is low and req_ready is high.
- R11: Request fields, root bus and secondary bus are sampled at acceptance. Changes to them during a packet do not alter the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Builder can accept a request |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_offset | input | 12 | Register byte offset |
| req_size | input | 2 | Access width: 0 byte, 1 halfword, 2/3 dword |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write value, right-aligned |
| root_bus | input | 8 | Bus number of the root port (requester) |
| sec_bus | input | 8 | Secondary bus number of the root port |
| out_valid | output | 1 | Beat present |
| out_ready | input | 1 | Sink accepts beat |
| out_data | output | 32 | Packet dword |
| out_sop | output | 1 | First beat of packet |
| out_eop | output | 1 | Last beat of packet |

## Verification
The first beat is due one cycle after the edge that accepts a request. Each following beat is due one cycle after the edge at which the previous beat meets out_ready. req_ready returns one cycle after the end-of-packet beat is accepted. The bench drives every input on the falling edge and samples every output on the next falling edge after the edge being checked, so each comparison falls exactly one register stage after its cause. Stalled beats are compared after a full cycle with out_ready low. Request inputs are scrambled right after acceptance so that any late sampling shows up in the packet.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;

    localparam int DW     = 32;
    localparam int NBEATS = 4;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int OFF_W  = 12;
    localparam int BE_W   = DW / 8;
    localparam int LANE_W = $clog2(BE_W);
    localparam int IDX_W  = OFF_W - LANE_W;

    localparam logic [7:0] TAG_RD  = 8'h1D;
    localparam logic [7:0] TAG_WR  = 8'h10;
    localparam logic [9:0] LEN_ONE = 10'd1;

    typedef logic [DW-1:0] dword_t;
    typedef dword_t [NBEATS-1:0] pkt_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [7:0]  fmt;
        logic [13:0] rsv;
        logic [9:0]  len;
    } hdr0_t;

    typedef struct packed {
        logic [BUS_W-1:0] rid_bus;
        logic [7:0]       rid_devfn;
        logic [7:0]       tag;
        logic [3:0]       rsv;
        logic [BE_W-1:0]  be;
    } hdr1_t;

    typedef struct packed {
        logic [BUS_W-1:0]    bus;
        logic [DEV_W-1:0]    dev;
        logic [FN_W-1:0]     fn;
        logic [3:0]          rsv;
        logic [IDX_W-1:0]    dw_idx;
        logic [LANE_W-1:0]   zero;
    } hdr2_t;

    // bit 6 selects write, bit 0 selects forwarded
    function automatic logic [7:0] fmt_code(input logic is_wr, input logic fwd);
        return {1'b0, is_wr, 5'b00010, fwd};
    endfunction

endpackage

// File: rtl/cfg_lane_steer.sv
module cfg_lane_steer
    import cfg_tlp_pkg::*;
(
    input  acc_size_e           size,
    input  logic [LANE_W-1:0]   lane,
    input  logic                is_wr,
    input  dword_t              wdata,
    output logic [BE_W-1:0]     be,
    output dword_t              data
);
    logic [LANE_W+2:0] sh;
    dword_t            placed;

    assign sh = {lane, 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                be     = BE_W'(4'b0001 << lane);
                placed = DW'(wdata[7:0]) << sh;
            end
            SZ_HALF: begin
                be     = BE_W'(4'b0011 << lane);
                placed = DW'(wdata[15:0]) << sh;
            end
            default: begin
                be     = '1;
                placed = wdata;
            end
        endcase
        data = is_wr ? placed : '0;
    end
endmodule

// File: rtl/cfg_hdr_encode.sv
module cfg_hdr_encode
    import cfg_tlp_pkg::*;
(
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  fn,
    input  logic [OFF_W-1:0] offset,
    input  logic             is_wr,
    input  logic [BUS_W-1:0] root_bus,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BE_W-1:0]  be,
    input  dword_t           data,
    output pkt_t             pkt
);
    hdr0_t            h0;
    hdr1_t            h1;
    hdr2_t            h2;
    logic             fwd;
    logic [OFF_W-1:0] aligned;

    assign fwd     = bus > sec_bus;
    assign aligned = offset & ~OFF_W'((1 << LANE_W) - 1);

    always_comb begin
        h0.fmt       = fmt_code(is_wr, fwd);
        h0.rsv       = '0;
        h0.len       = LEN_ONE;

        h1.rid_bus   = root_bus;
        h1.rid_devfn = '0;
        h1.tag       = is_wr ? TAG_WR : TAG_RD;
        h1.rsv       = '0;
        h1.be        = be;

        h2.bus       = bus;
        h2.dev       = dev;
        h2.fn        = fn;
        h2.rsv       = '0;
        h2.dw_idx    = aligned[OFF_W-1:LANE_W];
        h2.zero      = aligned[LANE_W-1:0];

        pkt[0] = dword_t'(h0);
        pkt[1] = dword_t'(h1);
        pkt[2] = dword_t'(h2);
        pkt[3] = data;
    end
endmodule

// File: rtl/cfg_beat_sequencer.sv
module cfg_beat_sequencer #(
    parameter int NB = 4,
    parameter int W  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [NB-1:0][W-1:0] pkt_in,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [W-1:0]         out_data,
    output logic                 out_sop,
    output logic                 out_eop
);
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [IW-1:0] LAST = IW'(NB - 1);

    logic [W-1:0]  beat_q [NB];
    logic [IW-1:0] idx_q;
    logic          active_q;

    for (genvar g = 0; g < NB; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (load) beat_q[g] <= pkt_in[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (load) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (active_q && out_ready) begin
            if (idx_q == LAST) begin
                active_q <= 1'b0;
                idx_q    <= '0;
            end else begin
                idx_q    <= idx_q + 1'b1;
            end
        end
    end

    assign out_valid = active_q;
    assign out_data  = beat_q[idx_q];
    assign out_sop   = active_q && (idx_q == '0);
    assign out_eop   = active_q && (idx_q == LAST);
endmodule

// File: rtl/cfg_tlp_builder.sv
module cfg_tlp_builder
    import cfg_tlp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DW-1:0]     req_wdata,
    input  logic [BUS_W-1:0]  root_bus,
    input  logic [BUS_W-1:0]  sec_bus,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DW-1:0]     out_data,
    output logic              out_sop,
    output logic              out_eop
);
    logic [BE_W-1:0] be;
    dword_t          data_dw;
    pkt_t            pkt;
    logic            accept;

    assign req_ready = !out_valid;
    assign accept    = req_valid && req_ready;

    cfg_lane_steer i_steer (
        .size  (acc_size_e'(req_size)),
        .lane  (req_offset[LANE_W-1:0]),
        .is_wr (req_write),
        .wdata (req_wdata),
        .be    (be),
        .data  (data_dw)
    );

    cfg_hdr_encode i_hdr (
        .bus      (req_bus),
        .dev      (req_dev),
        .fn       (req_fn),
        .offset   (req_offset),
        .is_wr    (req_write),
        .root_bus (root_bus),
        .sec_bus  (sec_bus),
        .be       (be),
        .data     (data_dw),
        .pkt      (pkt)
    );

    cfg_beat_sequencer #(.NB(NBEATS), .W(DW)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .pkt_in    (pkt),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );
endmodule

// File: rtl/cfg_tlp_builder_chk.sv
module cfg_tlp_builder_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_sop,
    input logic        out_eop
);
    // R1
    hdr0_form_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_sop |-> out_data[23:0] == 24'h000001 &&
            (out_data[31:24] inside {8'h04, 8'h44, 8'h05, 8'h45}));

    // R7
    marker_excl_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_sop && out_eop));

    // R7
    after_sop_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_sop |=> out_valid && !out_sop);

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !req_ready);

    // R8
    accept_start_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> out_valid && out_sop);

    // R8
    eop_release_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_eop |=> req_ready && !out_valid);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) &&
            $stable(out_sop) && $stable(out_eop));
endmodule

bind cfg_tlp_builder cfg_tlp_builder_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
);

// File: tb/test_cfg_tlp_builder.sv
module test_cfg_tlp_builder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [11:0] req_offset = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  root_bus = '0;
    logic [7:0]  sec_bus = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_sop;
    logic        out_eop;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cfg_tlp_builder i_cfg_tlp_builder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn),
        .req_offset(req_offset), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .root_bus(root_bus), .sec_bus(sec_bus),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    typedef struct packed {
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [11:0] off;
        logic [1:0]  size;
        logic        wr;
        logic [31:0] wdata;
        logic [7:0]  root;
        logic [7:0]  sec;
        logic [31:0] e0;
        logic [31:0] e1;
        logic [31:0] e2;
        logic [31:0] e3;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{8'd1, 5'd0,  3'd0, 12'h000, 2'd2, 1'b0, 32'hDEADBEEF, 8'h00, 8'h01,
          32'h04000001, 32'h00001D0F, 32'h01000000, 32'h00000000},
        '{8'd2, 5'd3,  3'd5, 12'h010, 2'd2, 1'b1, 32'h12345678, 8'h00, 8'h01,
          32'h45000001, 32'h0000100F, 32'h021D0010, 32'h12345678},
        '{8'd1, 5'd0,  3'd1, 12'h03D, 2'd0, 1'b1, 32'hAABBCCA5, 8'h00, 8'h01,
          32'h44000001, 32'h00001002, 32'h0101003C, 32'h0000A500},
        '{8'd5, 5'd31, 3'd7, 12'hFFE, 2'd1, 1'b1, 32'h9999BEEF, 8'h03, 8'h04,
          32'h45000001, 32'h0300100C, 32'h05FF0FFC, 32'hBEEF0000},
        '{8'd4, 5'd2,  3'd0, 12'h007, 2'd1, 1'b0, 32'h11111111, 8'h03, 8'h04,
          32'h04000001, 32'h03001D08, 32'h04100004, 32'h00000000},
        '{8'd6, 5'd1,  3'd2, 12'h02B, 2'd1, 1'b1, 32'h0000CAFE, 8'h7F, 8'h05,
          32'h45000001, 32'h7F001008, 32'h060A0028, 32'hFE000000},
        '{8'd0, 5'd0,  3'd0, 12'h0F3, 2'd0, 1'b0, 32'hFFFFFFFF, 8'h00, 8'h00,
          32'h04000001, 32'h00001D08, 32'h000000F0, 32'h00000000},
        '{8'd9, 5'd0,  3'd0, 12'h040, 2'd3, 1'b1, 32'h0F0F0F0F, 8'h01, 8'h02,
          32'h45000001, 32'h0100100F, 32'h09000040, 32'h0F0F0F0F}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input bit stall);
        logic [31:0] exp [4];
        string       tag [4];
        exp[0] = v.e0; exp[1] = v.e1; exp[2] = v.e2; exp[3] = v.e3;
        tag[0] = "R1 R2 dword0";
        tag[1] = "R3 R5 dword1";
        tag[2] = "R4 dword2";
        tag[3] = "R6 R11 dword3";
        @(negedge clk);
        req_bus = v.bus; req_dev = v.dev; req_fn = v.fn; req_offset = v.off;
        req_size = v.size; req_write = v.wr; req_wdata = v.wdata;
        root_bus = v.root; sec_bus = v.sec; req_valid = 1'b1;
        chk("R8 ready while idle", 32'(req_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // R11: scramble everything after acceptance
        req_bus = ~v.bus; req_dev = ~v.dev; req_fn = ~v.fn; req_offset = ~v.off;
        req_size = ~v.size; req_write = ~v.wr; req_wdata = ~v.wdata;
        root_bus = ~v.root; sec_bus = ~v.sec;
        for (int b = 0; b < 4; b++) begin
            if (stall) begin
                out_ready = 1'b0;
                @(posedge clk);
                @(negedge clk);
            end
            chk("R8 beat valid", 32'(out_valid), 32'd1);
            chk(stall ? {tag[b], " R9 after stall"} : tag[b], out_data, exp[b]);
            chk("R7 sop marker", 32'(out_sop), 32'(b == 0));
            chk("R7 eop marker", 32'(out_eop), 32'(b == 3));
            chk("R8 ready low while busy", 32'(req_ready), 32'd0);
            out_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
        end
        chk("R8 ready back after eop", 32'(req_ready), 32'd1);
        chk("R8 valid drops after eop", 32'(out_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 valid low in reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10 valid low after reset", 32'(out_valid), 32'd0);
        chk("R10 ready high after reset", 32'(req_ready), 32'd1);

        for (int v = 0; v < NV; v++) run_vec(TBL[v], (v % 2) == 1);

        // R10: reset mid-packet returns to idle
        @(negedge clk);
        req_bus = 8'd3; req_dev = 5'd0; req_fn = 3'd0; req_offset = 12'h0;
        req_size = 2'd2; req_write = 1'b0; root_bus = 8'd0; sec_bus = 8'd1;
        req_valid = 1'b1;
        out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 packet started", 32'(out_valid), 32'd1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset clears packet", 32'(out_valid), 32'd0);
        chk("R10 ready after mid reset", 32'(req_ready), 32'd1);
        out_ready = 1'b1;

        // R2 boundary: bus one above secondary selects forwarded
        run_vec('{8'd8, 5'd0, 3'd0, 12'h004, 2'd2, 1'b0, 32'h0, 8'h00, 8'h07,
                  32'h05000001, 32'h00001D0F, 32'h08000004, 32'h00000000}, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule